// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block sits between a simple host request port and one single-data-rate SDRAM device organised as four banks of 2048 rows by 256 columns of 32-bit words. After reset it waits a power-up interval, precharges every bank, issues two auto refresh commands and then writes the mode register. Only after that does it accept host traffic.

Each host request is a single 32-bit word with byte enables. The controller opens the addressed row, waits the row-to-column delay and issues the column command with auto precharge. It then holds off every further command until the bank is idle again. A refresh timer restarts at every auto refresh. Once it expires, the refresh is issued at the first idle point, ahead of any waiting host request. Read data returns in request order on a one-cycle response strobe. All timing limits are parameters counted in clocks.

Top module: `sdram_ctl`

## Requirements
- R1: While reset is high the memory pins show NOP (chip select low, row strobe, column strobe and write enable high), the data output enable is low, and both `req_ready` and `rsp_valid` are low.
- R2: The command encoding on {cs_n, ras_n, cas_n, we_n} is LMR=0000, AREF=0001, PRE=0010, ACT=0011, WRITE=0100, READ=0101 and NOP=0111. After reset the first commands are, in order: PRE with address bit 10 high (all banks), AREF, AREF, LMR. No ACT, READ or WRITE is issued before the LMR.
- R3: The LMR drives bank 0 and an address word whose bits 6:4 hold the CAS latency `CL`, with all other bits zero (burst of one, sequential, burst writes).
- R4: After PRE the next command waits at least `T_RP` cycles, after AREF at least `T_RFC`, and after LMR at least `T_MRD`.
- R5: Host address bits 20:19 select the bank, bits 18:8 the row and bits 7:0 the column. ACT drives the bank and row. READ or WRITE drives the same bank, the column on address bits 7:0 and address bit 10 high, so every access closes its row.
- R6: A READ or WRITE follows its ACT by at least `T_RCD` cycles.
- R7: In a WRITE cycle the controller drives the write data, raises the output enable and sets DQM to the inverse of the byte enables. A cleared byte enable leaves that byte unchanged. In all other cycles the output enable is low and DQM is zero.
- R8: Read data is sampled from the bus exactly `CL` cycles after the cycle in which READ is on the pins. It is returned with a one-cycle `rsp_valid` pulse, in request order.
- R9: After a WRITE the next command waits at least `T_WR+T_RP` cycles. After a READ it waits at least `CL+T_RP` cycles.
- R10: AREF is issued only when no row is open. Once initialization is done, AREF commands are never further apart than `REF_INTERVAL` plus one access time.
- R11: A refresh takes priority over host requests. ACT is never on the pins `REF_INTERVAL` or more cycles after the most recent AREF, plus one.
- R12: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low until initialization has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the memory |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address {bank, row, column} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i for byte lane i |
| rsp_valid | output | 1 | Read data strobe |
| rsp_rdata | output | 32 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 11 | Row, column or mode word |
| sd_dqm | output | 4 | Byte mask, one bit per lane |
| sd_dq_out | output | 32 | Data driven to the memory |
| sd_dq_oe | output | 1 | Output enable for the data bus |
| sd_dq_in | input | 32 | Data received from the memory |

## Verification
The timer that makes a refresh due and a host request waiting at the idle point can both be live in the same cycle. The bench keeps the request line busy with back-to-back requests across several refresh intervals, so the timer expires again and again while a request waits or while an access is still in flight. Each ACT is judged against the distance to the last AREF, and the spacing between consecutive AREFs is checked. A memory model on the pins confirms that every row was closed before each refresh, and that the data written and read back across these collisions matches the scoreboard.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    // Device geometry
    localparam int BA_W    = 2;
    localparam int A_W     = 11;
    localparam int COL_W   = 8;
    localparam int DQ_W    = 32;
    localparam int BE_W    = DQ_W / 8;
    localparam int HADDR_W = BA_W + A_W + COL_W;
    localparam int AP_BIT  = 10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR  = 4'b0000,
        CMD_AREF = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_NOP  = 4'b0111
    } cmd_e;

    typedef struct packed {
        cmd_e            cmd;
        logic [BA_W-1:0] ba;
        logic [A_W-1:0]  a;
    } bus_t;

    typedef enum logic [2:0] {
        ST_POWER,
        ST_INIT_REF,
        ST_LOAD_MODE,
        ST_IDLE,
        ST_ACCESS
    } state_e;

    localparam bus_t BUS_NOP = '{cmd: CMD_NOP, ba: '0, a: '0};

    function automatic int unsigned max2(int unsigned x, int unsigned y);
        return (x > y) ? x : y;
    endfunction

    // Counter load value for a gap of v clocks between commands
    function automatic int unsigned gap_load(int unsigned v);
        return (v > 1) ? v - 1 : 0;
    endfunction

    // Burst of one, sequential order, latency in bits 6:4
    function automatic logic [A_W-1:0] mode_word(int unsigned cl);
        logic [A_W-1:0] w;
        w      = '0;
        w[6:4] = cl[2:0];
        return w;
    endfunction

endpackage

// File: rtl/sdc_countdown.sv
module sdc_countdown #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0,
    parameter int unsigned MAXV    = 255
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= W'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(MAXV));
endmodule

// File: rtl/sdc_refresh.sv
module sdc_refresh #(
    parameter int unsigned INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic due
);
    localparam int unsigned W = $clog2(INTERVAL + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)                 cnt <= '0;
        else if (cnt < W'(INTERVAL))    cnt <= cnt + 1'b1;
    end

    assign due = (cnt >= W'(INTERVAL));

    // R11
    ref_sat_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(INTERVAL));
    // R10
    due_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (due && !clr) |=> due);
endmodule

// File: rtl/sdc_rdpipe.sv
module sdc_rdpipe #(
    parameter int unsigned CL   = 3,
    parameter int unsigned DW   = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_on_pins,
    input  logic [DW-1:0] dq_in,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    logic [CL-1:0] stage;

    generate
        if (CL == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage <= '0;
                else     stage <= rd_on_pins;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) stage <= '0;
                else     stage <= {stage[CL-2:0], rd_on_pins};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= stage[CL-1];
            if (stage[CL-1]) rsp_rdata <= dq_in;
        end
    end

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sdram_ctl.sv
module sdram_ctl
    import sdc_pkg::*;
#(
    parameter int unsigned CL           = 3,
    parameter int unsigned T_RCD        = 3,
    parameter int unsigned T_RP         = 3,
    parameter int unsigned T_RFC        = 10,
    parameter int unsigned T_MRD        = 2,
    parameter int unsigned T_WR         = 2,
    parameter int unsigned INIT_CYC     = 10000,
    parameter int unsigned INIT_REFS    = 2,
    parameter int unsigned REF_INTERVAL = 1560
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [HADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]    req_wdata,
    input  logic [BE_W-1:0]    req_be,
    output logic               rsp_valid,
    output logic [DQ_W-1:0]    rsp_rdata,
    output logic               sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [BA_W-1:0]    sd_ba,
    output logic [A_W-1:0]     sd_a,
    output logic [BE_W-1:0]    sd_dqm,
    output logic [DQ_W-1:0]    sd_dq_out,
    output logic               sd_dq_oe,
    input  logic [DQ_W-1:0]    sd_dq_in
);
    localparam int unsigned RD_TAIL = CL + T_RP;
    localparam int unsigned WR_TAIL = T_WR + T_RP;
    localparam int unsigned MAXV    = max2(max2(max2(INIT_CYC, T_RFC), max2(RD_TAIL, WR_TAIL)),
                                           max2(max2(T_RCD, T_RP), T_MRD));
    localparam int unsigned CW      = $clog2(MAXV + 1);
    localparam int unsigned NREF_W  = $clog2(INIT_REFS + 1);

    localparam logic [CW-1:0] LD_RP  = CW'(gap_load(T_RP));
    localparam logic [CW-1:0] LD_RFC = CW'(gap_load(T_RFC));
    localparam logic [CW-1:0] LD_MRD = CW'(gap_load(T_MRD));
    localparam logic [CW-1:0] LD_RCD = CW'(gap_load(T_RCD));
    localparam logic [CW-1:0] LD_RDT = CW'(gap_load(RD_TAIL));
    localparam logic [CW-1:0] LD_WRT = CW'(gap_load(WR_TAIL));

    state_e              state_q, state_d;
    bus_t                bus_q, bus_d;
    logic                oe_q, oe_d;
    logic [DQ_W-1:0]     dout_q, dout_d;
    logic [BE_W-1:0]     dqm_q, dqm_d;
    logic [NREF_W-1:0]   nref_q, nref_d;
    logic                mode_q, mode_d;
    logic                take;

    logic                lat_write;
    logic [BA_W-1:0]     lat_bank;
    logic [COL_W-1:0]    lat_col;
    logic [DQ_W-1:0]     lat_wdata;
    logic [BE_W-1:0]     lat_be;

    logic                tmr_load, tmr_zero;
    logic [CW-1:0]       tmr_val;
    logic                ref_due;

    sdc_countdown #(.W(CW), .RST_VAL(INIT_CYC), .MAXV(MAXV)) u_wait (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    sdc_refresh #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst(rst), .clr(bus_d.cmd == CMD_AREF), .due(ref_due)
    );

    sdc_rdpipe #(.CL(CL), .DW(DQ_W)) u_rd (
        .clk(clk), .rst(rst), .rd_on_pins(bus_q.cmd == CMD_RD),
        .dq_in(sd_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    assign req_ready = (state_q == ST_IDLE) && tmr_zero && !ref_due;

    always_comb begin
        state_d  = state_q;
        bus_d    = BUS_NOP;
        tmr_load = 1'b0;
        tmr_val  = '0;
        oe_d     = 1'b0;
        dout_d   = dout_q;
        dqm_d    = '0;
        nref_d   = nref_q;
        mode_d   = mode_q;
        take     = 1'b0;
        case (state_q)
            ST_POWER: if (tmr_zero) begin
                bus_d.cmd       = CMD_PRE;
                bus_d.a[AP_BIT] = 1'b1;
                tmr_load        = 1'b1;
                tmr_val         = LD_RP;
                state_d         = ST_INIT_REF;
            end
            ST_INIT_REF: if (tmr_zero) begin
                bus_d.cmd = CMD_AREF;
                tmr_load  = 1'b1;
                tmr_val   = LD_RFC;
                nref_d    = nref_q + 1'b1;
                if (nref_q == NREF_W'(INIT_REFS - 1)) state_d = ST_LOAD_MODE;
            end
            ST_LOAD_MODE: if (tmr_zero) begin
                bus_d.cmd = CMD_LMR;
                bus_d.a   = mode_word(CL);
                tmr_load  = 1'b1;
                tmr_val   = LD_MRD;
                mode_d    = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_IDLE: if (tmr_zero) begin
                if (ref_due) begin
                    bus_d.cmd = CMD_AREF;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_RFC;
                end else if (req_valid) begin
                    bus_d.cmd = CMD_ACT;
                    bus_d.ba  = req_addr[HADDR_W-1 -: BA_W];
                    bus_d.a   = req_addr[COL_W +: A_W];
                    tmr_load  = 1'b1;
                    tmr_val   = LD_RCD;
                    take      = 1'b1;
                    state_d   = ST_ACCESS;
                end
            end
            ST_ACCESS: if (tmr_zero) begin
                bus_d.cmd              = lat_write ? CMD_WR : CMD_RD;
                bus_d.ba               = lat_bank;
                bus_d.a[COL_W-1:0]     = lat_col;
                bus_d.a[AP_BIT]        = 1'b1;
                tmr_load               = 1'b1;
                tmr_val                = lat_write ? LD_WRT : LD_RDT;
                if (lat_write) begin
                    oe_d   = 1'b1;
                    dout_d = lat_wdata;
                    dqm_d  = ~lat_be;
                end
                state_d = ST_IDLE;
            end
            default: state_d = ST_POWER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_POWER;
            bus_q   <= BUS_NOP;
            oe_q    <= 1'b0;
            dout_q  <= '0;
            dqm_q   <= '0;
            nref_q  <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            bus_q   <= bus_d;
            oe_q    <= oe_d;
            dout_q  <= dout_d;
            dqm_q   <= dqm_d;
            nref_q  <= nref_d;
            mode_q  <= mode_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_write <= 1'b0;
            lat_bank  <= '0;
            lat_col   <= '0;
            lat_wdata <= '0;
            lat_be    <= '0;
        end else if (take) begin
            lat_write <= req_write;
            lat_bank  <= req_addr[HADDR_W-1 -: BA_W];
            lat_col   <= req_addr[COL_W-1:0];
            lat_wdata <= req_wdata;
            lat_be    <= req_be;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = bus_q.cmd;
    assign sd_ba     = bus_q.ba;
    assign sd_a      = bus_q.a;
    assign sd_dqm    = dqm_q;
    assign sd_dq_out = dout_q;
    assign sd_dq_oe  = oe_q;

    // Cycles since the last ACT on the pins, saturating; used only by a check
    logic [CW-1:0] since_act;
    always_ff @(posedge clk) begin
        if (rst)                          since_act <= CW'(T_RCD);
        else if (bus_q.cmd == CMD_ACT)    since_act <= CW'(1);
        else if (since_act < CW'(T_RCD))  since_act <= since_act + 1'b1;
    end

    // R2
    early_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_q |-> !(bus_q.cmd inside {CMD_ACT, CMD_RD, CMD_WR}));
    // R6
    rcd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_q.cmd inside {CMD_RD, CMD_WR}) |-> (since_act >= CW'(T_RCD)));
    // R7
    oe_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (bus_q.cmd == CMD_WR));
    // R7
    dqm_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_q.cmd != CMD_WR) |-> (sd_dqm == '0));
    // R12
    ready_after_init_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mode_q);
endmodule

// File: tb/tb_sdram_ctl.sv
module tb_sdram_ctl;
    import sdc_pkg::*;

    localparam int unsigned CL = 2, T_RCD = 2, T_RP = 2, T_RFC = 6, T_MRD = 2, T_WR = 2;
    localparam int unsigned INIT_CYC = 30, REF_INTERVAL = 120;
    localparam int unsigned RD_TAIL = CL + T_RP, WR_TAIL = T_WR + T_RP;
    localparam int unsigned SLACK = T_RCD + ((RD_TAIL > WR_TAIL) ? RD_TAIL : WR_TAIL) + 2;
    localparam logic [31:0] POISON = 32'hBAD0_BAD0;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [HADDR_W-1:0] req_addr = '0;
    logic [DQ_W-1:0] req_wdata = '0;
    logic [BE_W-1:0] req_be = '0;
    logic req_ready, rsp_valid;
    logic [DQ_W-1:0] rsp_rdata;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [BA_W-1:0] sd_ba;
    logic [A_W-1:0] sd_a;
    logic [BE_W-1:0] sd_dqm;
    logic [DQ_W-1:0] sd_dq_out, sd_dq_in;

    always #5 clk = ~clk;

    sdram_ctl #(.CL(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
                .T_WR(T_WR), .INIT_CYC(INIT_CYC), .INIT_REFS(2), .REF_INTERVAL(REF_INTERVAL)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard state
    logic [31:0] shadow [int];
    logic [31:0] expq [$];

    // Pin-level memory model
    logic [31:0] mem [int];
    logic [31:0] rpipe [0:4];
    bit          open_b [0:3];
    logic [A_W-1:0] open_row [0:3];
    int  cyc = 0, step = 0, prev_cyc = 0, last_aref = 0, arefs_run = 0;
    bit  prev_ok = 0, ref_late = 0;
    cmd_e prev_cmd = CMD_NOP;
    bit  acc_write;
    logic [BA_W-1:0] acc_bank;
    logic [A_W-1:0]  acc_row;
    logic [COL_W-1:0] acc_col;
    logic [31:0] acc_wdata;
    logic [3:0]  acc_be;

    initial begin
        for (int i = 0; i < 5; i++) rpipe[i] = POISON;
        for (int i = 0; i < 4; i++) begin open_b[i] = 0; open_row[i] = '0; end
        sd_dq_in = POISON;
    end

    function automatic int unsigned gap_of(cmd_e c);
        case (c)
            CMD_PRE:  return T_RP;
            CMD_AREF: return T_RFC;
            CMD_LMR:  return T_MRD;
            CMD_ACT:  return T_RCD;
            CMD_WR:   return WR_TAIL;
            CMD_RD:   return RD_TAIL;
            default:  return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        cmd_e c;
        int   key;
        logic [31:0] old;
        cyc++;
        for (int i = 0; i < 4; i++) rpipe[i] = rpipe[i+1];
        rpipe[4] = POISON;
        sd_dq_in = rpipe[0];
        c = cmd_e'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
        if (rst) begin
            // R1 reset state
            check(c == CMD_NOP && !sd_dq_oe && !req_ready && !rsp_valid, "R1", "reset pins",
                  {sd_dq_oe, req_ready, rsp_valid, 4'(c)}, {3'b000, 4'(CMD_NOP)});
        end else begin
            if (step < 4) check(!req_ready, "R12", "ready during init", req_ready, 0);
            if (req_valid && req_ready) begin
                acc_write = req_write; acc_wdata = req_wdata; acc_be = req_be;
                acc_bank = req_addr[20:19]; acc_row = req_addr[18:8]; acc_col = req_addr[7:0];
            end
            if (rsp_valid) begin
                if (expq.size() == 0) check(0, "R8", "response with none pending", rsp_rdata, 0);
                else begin
                    old = expq.pop_front();
                    check(rsp_rdata == old, "R8", "read data", rsp_rdata, old);
                end
            end
            if (c != CMD_WR)
                check(!sd_dq_oe && sd_dqm == 4'b0, "R7", "idle oe/dqm", {sd_dq_oe, sd_dqm}, 0);
            if (c != CMD_NOP) begin
                if (prev_ok) begin
                    if (prev_cmd inside {CMD_PRE, CMD_AREF, CMD_LMR})
                        check(cyc - prev_cyc >= int'(gap_of(prev_cmd)), "R4", "init/refresh gap",
                              cyc - prev_cyc, gap_of(prev_cmd));
                    else if (prev_cmd == CMD_ACT)
                        check(cyc - prev_cyc >= int'(T_RCD), "R6", "act to column gap",
                              cyc - prev_cyc, T_RCD);
                    else
                        check(cyc - prev_cyc >= int'(gap_of(prev_cmd)), "R9", "recovery gap",
                              cyc - prev_cyc, gap_of(prev_cmd));
                end
                case (step)
                    0: begin check(c == CMD_PRE && sd_a[10], "R2", "first cmd", {4'(c), sd_a[10]},
                                   {4'(CMD_PRE), 1'b1}); step = 1; end
                    1, 2: begin check(c == CMD_AREF, "R2", "init refresh", c, CMD_AREF); step++; end
                    3: begin
                        check(c == CMD_LMR, "R2", "mode load", c, CMD_LMR);
                        check(sd_a == 11'(CL << 4) && sd_ba == 0, "R3", "mode word",
                              {sd_ba, sd_a}, 11'(CL << 4));
                        step = 4;
                    end
                    default: ;
                endcase
                case (c)
                    CMD_ACT: begin
                        check(sd_ba == acc_bank && sd_a == acc_row, "R5", "act bank/row",
                              {sd_ba, sd_a}, {acc_bank, acc_row});
                        check(cyc - last_aref <= int'(REF_INTERVAL), "R11", "act after refresh due",
                              cyc - last_aref, REF_INTERVAL);
                        open_b[sd_ba] = 1; open_row[sd_ba] = sd_a;
                    end
                    CMD_RD, CMD_WR: begin
                        check(sd_ba == acc_bank && sd_a[7:0] == acc_col && sd_a[10] && open_b[sd_ba],
                              "R5", "column cmd", {sd_ba, sd_a}, {acc_bank, 3'b100, acc_col});
                        key = int'({sd_ba, open_row[sd_ba], sd_a[7:0]});
                        old = mem.exists(key) ? mem[key] : 32'h0;
                        if (c == CMD_WR) begin
                            check(sd_dq_oe && sd_dq_out == acc_wdata && sd_dqm == ~acc_be, "R7",
                                  "write drive", {sd_dq_oe, sd_dqm, sd_dq_out}, {1'b1, ~acc_be, acc_wdata});
                            for (int b = 0; b < 4; b++)
                                if (!sd_dqm[b]) old[b*8 +: 8] = sd_dq_out[b*8 +: 8];
                            mem[key] = old;
                        end else rpipe[CL] = old;
                        open_b[sd_ba] = 0;
                    end
                    CMD_AREF: begin
                        check(!(open_b[0] | open_b[1] | open_b[2] | open_b[3]), "R10",
                              "refresh with open row", 1, 0);
                        if (step == 4) begin
                            check(cyc - last_aref <= int'(REF_INTERVAL + SLACK), "R10", "refresh spacing",
                                  cyc - last_aref, REF_INTERVAL + SLACK);
                            arefs_run++;
                        end
                        last_aref = cyc;
                    end
                    default: ;
                endcase
                prev_cmd = c; prev_cyc = cyc; prev_ok = 1;
            end
            if (step == 4 && !ref_late && cyc - last_aref > int'(REF_INTERVAL + SLACK)) begin
                ref_late = 1;
                check(0, "R10", "refresh overdue", cyc - last_aref, REF_INTERVAL + SLACK);
            end
        end
    end

    // Driver: one request, scoreboard updated from the requirements
    task automatic host_op(bit wr, logic [20:0] addr, logic [31:0] data, logic [3:0] be);
        bit got;
        logic [31:0] v;
        int k = int'(addr);
        v = shadow.exists(k) ? shadow[k] : 32'h0;
        if (wr) begin
            for (int b = 0; b < 4; b++) if (be[b]) v[b*8 +: 8] = data[b*8 +: 8];
            shadow[k] = v;
        end else expq.push_back(v);
        @(posedge clk); #1;
        req_valid = 1; req_write = wr; req_addr = addr; req_wdata = data; req_be = be;
        do begin
            @(negedge clk); got = req_ready;
            @(posedge clk);
        end while (!got);
        #1 req_valid = 0;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 0;
        while (step < 4) @(posedge clk);
        // R5 R7 R8: assorted banks, rows, columns, full writes then reads
        for (int i = 0; i < 8; i++)
            host_op(1, {2'(i), 11'(i * 257), 8'(i * 31)}, 32'h1000_0000 + i * 32'h0101_0101, 4'hF);
        for (int i = 0; i < 8; i++)
            host_op(0, {2'(i), 11'(i * 257), 8'(i * 31)}, 0, 4'h0);
        // R5 boundary: last bank, row and column
        host_op(1, {2'd3, 11'd2047, 8'd255}, 32'hCAFE_F00D, 4'hF);
        host_op(0, {2'd3, 11'd2047, 8'd255}, 0, 4'h0);
        // R7 partial byte enables, then none at all
        host_op(1, {2'd1, 11'd5, 8'd9}, 32'h1122_3344, 4'hF);
        host_op(1, {2'd1, 11'd5, 8'd9}, 32'hAABB_CCDD, 4'b0101);
        host_op(0, {2'd1, 11'd5, 8'd9}, 0, 4'h0);
        host_op(1, {2'd1, 11'd5, 8'd9}, 32'hFFFF_FFFF, 4'b0000);
        host_op(0, {2'd1, 11'd5, 8'd9}, 0, 4'h0);
        // R10 R11: continuous traffic across several refresh intervals
        for (int i = 0; i < 60; i++) begin
            host_op(1, {2'(i), 11'(i * 13), 8'(i * 7)}, 32'h5A00_0000 ^ i, 4'(i | 1));
            host_op(0, {2'(i), 11'(i * 13), 8'(i * 7)}, 0, 4'h0);
        end
        repeat (20) @(posedge clk);
        check(expq.size() == 0, "R8", "responses outstanding", expq.size(), 0);
        check(arefs_run >= 3, "R10", "refreshes under load", arefs_run, 3);
        check(step == 4, "R2", "init completed", step, 4);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R12 watchdog: actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule